// File: doc/BRIEF.md
# Color Palette Lookup Table

This block holds a 256-entry color table in which every entry is a red, green and blue triple of 6-bit components. Software loads and inspects the table through a byte-wide register port with four addresses: a write-index register, a read-index register, a data register and a pixel-mask register. Writing an index register selects an entry. Successive data accesses then step through that entry's red, green and blue components and move on to the next entry on their own, so a whole range of colors can be streamed without re-addressing.

The loading pointer and the readback pointer are independent. Each has its own component sub-counter, so readback can be interleaved with loading.

A separate pixel path takes an 8-bit color index and returns the matching entry one clock later as a 24-bit RGB word. In that word each component is widened from 6 to 8 bits by repeating its least significant bit. After reset the first sixteen entries hold a fixed 16-color default set, so the table shows sensible colors before software touches it.

Top module: `pal_ram`

## Requirements
- R1: A register write to address 0 (write index) loads the write entry pointer from the data byte and clears the write component counter to 0 (red).
- R2: A register write to address 2 (read index) loads a read entry pointer, independent of the write pointer, and clears the read component counter to 0 (red).
- R3: Register writes to address 1 (data) store red, then green, then blue of the entry at the write pointer. After blue the write pointer increments by one, wrapping from 255 to 0, and the counter returns to red.
- R4: While address 1 is presented, reg_rdata shows the component of the entry at the read pointer that the read counter selects. A read strobe on address 1 advances the read counter in the order red, green, blue, and after blue the read pointer increments by one, wrapping from 255 to 0. On any other address reg_rdata is 0.
- R5: Only bits 5:0 of a written data byte are stored. Bits 7:6 of reg_rdata are always 0.
- R6: lut_rgb carries the entry addressed by lut_idx at the previous rising clock edge, with red in bits 23:16, green in bits 15:8 and blue in bits 7:0. Each 6-bit component c is presented as {c, c[0], c[0]}.
- R7: After reset lut_rgb is 0. For entry i with i below 16: red is 0x2A when i[2] is set and 0 otherwise; green is 0x2A when i[1] is set and 0 otherwise; blue is the sum of 0x2A when i[0] is set and 0x15 when i[3] is set. Every other entry is all zero.
- R8: A register write to address 3 (pixel mask) changes neither the table, nor either pointer, nor either component counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address: 0 write index, 1 data, 2 read index, 3 pixel mask |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| lut_idx | input | 8 | Pixel color index |
| lut_rgb | output | 24 | Registered 24-bit RGB color for lut_idx |

## Verification
The bench builds the block with its default parameters: 256 entries, 6-bit components and byte-wide data. This makes the full pointer range reachable, so the 255-to-0 wrap of both pointers can be driven directly. The 8-bit data byte is wider than a component, which lets writes with bits 7:6 set exercise the discarded upper bits. Random interleaving of index loads, data writes, data reads, mask writes and lookups works the independent sub-counters against each other across entry boundaries.

// File: rtl/pal_ram.sv
module pal_ram #(
  parameter int ENTRIES = 256,
  parameter int COMP_W  = 6,
  parameter int DATA_W  = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic                reg_rd,
  input  logic [1:0]          reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  input  logic [$clog2(ENTRIES)-1:0] lut_idx,
  output logic [3*DATA_W-1:0] lut_rgb
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int EXT_W = DATA_W - COMP_W;
  localparam logic [1:0] A_WIDX = 2'd0, A_DATA = 2'd1, A_RIDX = 2'd2;

  logic [COMP_W-1:0] red [ENTRIES];
  logic [COMP_W-1:0] grn [ENTRIES];
  logic [COMP_W-1:0] blu [ENTRIES];
  logic [IDX_W-1:0]  wptr, rptr;
  logic [1:0]        wsub, rsub;
  logic [COMP_W-1:0] rcomp;

  wire wr_data = reg_wr && reg_addr == A_DATA;
  wire rd_data = reg_rd && reg_addr == A_DATA;

  function automatic logic [COMP_W-1:0] dflt(input int i, input int comp);
    logic [5:0] v;
    v = 6'h00;
    if (i < 16) begin
      case (comp)
        0: v = i[2] ? 6'h2A : 6'h00;
        1: v = i[1] ? 6'h2A : 6'h00;
        default: v = (i[0] ? 6'h2A : 6'h00) + (i[3] ? 6'h15 : 6'h00);
      endcase
    end
    return COMP_W'(v);
  endfunction

  function automatic logic [DATA_W-1:0] widen(input logic [COMP_W-1:0] c);
    return {c, {EXT_W{c[0]}}};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        red[i] <= dflt(i, 0);
        grn[i] <= dflt(i, 1);
        blu[i] <= dflt(i, 2);
      end
    end else if (wr_data) begin
      case (wsub)
        2'd0:    red[wptr] <= reg_wdata[COMP_W-1:0];
        2'd1:    grn[wptr] <= reg_wdata[COMP_W-1:0];
        default: blu[wptr] <= reg_wdata[COMP_W-1:0];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr <= '0;
      wsub <= 2'd0;
    end else if (reg_wr && reg_addr == A_WIDX) begin
      wptr <= reg_wdata[IDX_W-1:0];
      wsub <= 2'd0;
    end else if (wr_data) begin
      wsub <= (wsub == 2'd2) ? 2'd0 : wsub + 2'd1;
      if (wsub == 2'd2) wptr <= wptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rptr <= '0;
      rsub <= 2'd0;
    end else if (reg_wr && reg_addr == A_RIDX) begin
      rptr <= reg_wdata[IDX_W-1:0];
      rsub <= 2'd0;
    end else if (rd_data) begin
      rsub <= (rsub == 2'd2) ? 2'd0 : rsub + 2'd1;
      if (rsub == 2'd2) rptr <= rptr + 1'b1;
    end
  end

  always_comb begin
    case (rsub)
      2'd0:    rcomp = red[rptr];
      2'd1:    rcomp = grn[rptr];
      default: rcomp = blu[rptr];
    endcase
  end

  assign reg_rdata = (reg_addr == A_DATA) ? {{EXT_W{1'b0}}, rcomp} : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) lut_rgb <= '0;
    else        lut_rgb <= {widen(red[lut_idx]), widen(grn[lut_idx]), widen(blu[lut_idx])};
  end
endmodule

// File: rtl/pal_ram_chk.sv
module pal_ram_chk #(
  parameter int IDX_W  = 8,
  parameter int COMP_W = 6,
  parameter int DATA_W = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                reg_wr,
  input logic                reg_rd,
  input logic [1:0]          reg_addr,
  input logic [DATA_W-1:0]   reg_wdata,
  input logic [DATA_W-1:0]   reg_rdata,
  input logic [3*DATA_W-1:0] lut_rgb,
  input logic [IDX_W-1:0]    wptr,
  input logic [IDX_W-1:0]    rptr,
  input logic [1:0]          wsub,
  input logic [1:0]          rsub
);
  localparam int E = DATA_W - COMP_W;

  p_widx_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd0) |=> (wptr == $past(reg_wdata[IDX_W-1:0]) && wsub == 2'd0));

  p_ridx_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd2) |=> (rptr == $past(reg_wdata[IDX_W-1:0]) && rsub == 2'd0 && $stable(wptr)));

  p_wr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd1 && wsub == 2'd2) |=> (wptr == $past(wptr) + 1'b1 && wsub == 2'd0));

  p_rd_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && !reg_wr && reg_addr == 2'd1 && rsub == 2'd2) |=> (rptr == $past(rptr) + 1'b1 && rsub == 2'd0));

  p_rdata_upper_r5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[DATA_W-1:COMP_W] == '0);

  p_widen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (lut_rgb[2*DATA_W+E] == lut_rgb[2*DATA_W] && lut_rgb[2*DATA_W+E] == lut_rgb[2*DATA_W+E-1] &&
     lut_rgb[DATA_W+E]   == lut_rgb[DATA_W]   && lut_rgb[DATA_W+E]   == lut_rgb[DATA_W+E-1] &&
     lut_rgb[E]          == lut_rgb[0]        && lut_rgb[E]          == lut_rgb[E-1]));

  p_mask_noop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_rd && reg_addr == 2'd3) |=> ($stable(wptr) && $stable(rptr) && $stable(wsub) && $stable(rsub)));
endmodule

bind pal_ram pal_ram_chk #(.IDX_W(IDX_W), .COMP_W(COMP_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lut_rgb(lut_rgb),
  .wptr(wptr), .rptr(rptr), .wsub(wsub), .rsub(rsub)
);

// File: tb/sim_pal_ram.sv
module sim_pal_ram;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic [7:0] lut_idx = 8'd0;
  logic [23:0] lut_rgb;

  always #5 clk = ~clk;

  pal_ram u0 (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
              .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lut_idx(lut_idx), .lut_rgb(lut_rgb));

  int nvec = 0, nfail = 0;
  bit done = 1'b0;
  logic [5:0] m_c [256][3];
  logic [7:0] m_wp, m_rp;
  int m_ws, m_rs;

  function automatic logic [5:0] dflt(int i, int c);
    logic [3:0] b = i[3:0];
    if (i >= 16) return 6'h00;
    if (c == 0) return b[2] ? 6'h2A : 6'h00;
    if (c == 1) return b[1] ? 6'h2A : 6'h00;
    return (b[0] ? 6'h2A : 6'h00) + (b[3] ? 6'h15 : 6'h00);
  endfunction

  function automatic logic [23:0] exp_rgb(logic [7:0] i);
    logic [23:0] v;
    for (int c = 0; c < 3; c++) begin
      logic [5:0] x = m_c[i][c];
      v[23-8*c -: 8] = {x, x[0], x[0]};
    end
    return v;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_reg(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    case (a)
      2'd0: begin m_wp = d; m_ws = 0; end
      2'd2: begin m_rp = d; m_rs = 0; end
      2'd1: begin
        m_c[m_wp][m_ws] = d[5:0];
        if (m_ws == 2) begin m_ws = 0; m_wp++; end else m_ws++;
      end
      default: ;
    endcase
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_data(string req);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = 2'd1;
    #1;
    check(req, {24'd0, reg_rdata}, {26'd0, m_c[m_rp][m_rs]});
    if (m_rs == 2) begin m_rs = 0; m_rp++; end else m_rs++;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic chk_lut(logic [7:0] i, string req);
    @(negedge clk);
    lut_idx = i;
    @(negedge clk);
    check(req, {8'd0, lut_rgb}, {8'd0, exp_rgb(i)});
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1c0ffee));
    for (int i = 0; i < 256; i++) for (int c = 0; c < 3; c++) m_c[i][c] = dflt(i, c);
    m_wp = 0; m_rp = 0; m_ws = 0; m_rs = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R7 lut reset", {8'd0, lut_rgb}, 32'd0);

    // R7/R4: stream defaults 0..16 back through the data port
    wr_reg(2'd2, 8'd0);
    for (int i = 0; i < 17 * 3; i++) rd_data("R7 default via R4 readback");
    chk_lut(8'd9, "R7 R6 entry 9");
    chk_lut(8'd1, "R6 entry 1 widen");
    chk_lut(8'd200, "R7 upper entry zero");

    // R4: non-data address reads zero
    @(negedge clk); reg_addr = 2'd0; #1; check("R4 idx addr reads 0", {24'd0, reg_rdata}, 32'd0);

    // R3/R5: wrap and upper bits discarded
    wr_reg(2'd0, 8'd255);
    wr_reg(2'd1, 8'hFF); wr_reg(2'd1, 8'hC1); wr_reg(2'd1, 8'h80);
    wr_reg(2'd1, 8'h3E); wr_reg(2'd1, 8'h01); wr_reg(2'd1, 8'h7F);
    wr_reg(2'd2, 8'd255);
    for (int i = 0; i < 6; i++) rd_data("R3 R4 R5 wrap 255->0");
    chk_lut(8'd255, "R6 R5 entry 255");
    chk_lut(8'd0, "R3 wrapped entry 0");

    // R1/R8: mask write mid-entry leaves pointers and table alone
    wr_reg(2'd0, 8'd40);
    wr_reg(2'd1, 8'h11);
    wr_reg(2'd3, 8'h00);
    wr_reg(2'd1, 8'h22);
    wr_reg(2'd3, 8'hFF);
    wr_reg(2'd1, 8'h33);
    chk_lut(8'd40, "R8 R1 mask write no effect");
    wr_reg(2'd2, 8'd40);
    rd_data("R8 R2 readback red");
    wr_reg(2'd3, 8'h5A);
    rd_data("R8 readback green");
    rd_data("R8 readback blue");

    // R1: reload write index mid-entry restarts at red
    wr_reg(2'd0, 8'd41);
    wr_reg(2'd1, 8'h05);
    wr_reg(2'd0, 8'd42);
    wr_reg(2'd1, 8'h06); wr_reg(2'd1, 8'h07); wr_reg(2'd1, 8'h08);
    chk_lut(8'd41, "R1 partial entry 41");
    chk_lut(8'd42, "R1 restart entry 42");

    // random mix
    for (int n = 0; n < 600; n++) begin
      int op = $urandom_range(0, 9);
      case (op)
        0:       wr_reg(2'd0, 8'($urandom));
        1:       wr_reg(2'd2, 8'($urandom));
        2, 3, 4: wr_reg(2'd1, 8'($urandom));
        5, 6:    rd_data("R2 R3 R4 random");
        7:       wr_reg(2'd3, 8'($urandom));
        default: chk_lut(8'($urandom), "R6 random lookup");
      endcase
    end
    for (int i = 0; i < 256; i += 17) chk_lut(8'(i), "R6 sweep");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule